// File: doc/BRIEF.md
# Multi-Channel Match-Based PWM Timer

This block is a PWM timer. A prescaler divides the clock into count ticks, and each tick advances a timer counter. The counter is compared against one restart register and six edge registers. Each compare register carries three independent actions, selected in a match-action word: raise a sticky interrupt flag, return the counter to zero, or halt the counter and clear its run bit. The first compare register usually restarts the counter, so its value sets the PWM period.

The block drives six PWM outputs, each with its own enable bit. Output 1 is always single-edge. Outputs 2 to 6 each choose single-edge or double-edge mode. In single-edge mode output n rises at the restart and falls on a match with compare register n. In double-edge mode output n rises on a match with compare register n-1 and falls on a match with compare register n.

Software reaches the block through a plain synchronous write port and a combinational read port. That port holds the timer control, the prescale value, the match-action word, the output control word, the interrupt flags, read-only views of both counters, and the compare values.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset, every register reads 0, all PWM outputs are low and the interrupt output is low.
- R2: Address 0 is the timer control word. Bit 0 lets the counter run and bit 1 holds both counters at zero. While bit 0 is 1, the timer counter (read at address 5) advances once every prescale+1 clocks, where prescale is the value at address 1. While bit 0 is 0, the counter holds its value.
- R3: A match-action word sits at address 2. Compare register k (at address 8+k) owns bits 3k (interrupt), 3k+1 (restart) and 3k+2 (halt). With the restart bit set, a tick on which the counter equals register k returns the counter to 0, so the counter never exceeds that value.
- R4: With the halt bit set, such a match freezes the counter at the match value and clears timer control bit 0.
- R5: With the interrupt bit set, such a match sets sticky flag k in the flag register (address 4). With the bit clear, no flag is set. The interrupt output is the OR of all flags.
- R6: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R7: Output control (address 3) bits 8 to 12 select double-edge mode for outputs 2 to 6, where 0 means single-edge. In single-edge mode output n is high for (MRn+1)·(prescale+1) clocks of each period when compare register 0 restarts the counter.
- R8: In double-edge mode output n is high for (MRn − MR(n−1))·(prescale+1) clocks of each period.
- R9: Output control bits 0 to 5 enable outputs 1 to 6. A disabled output stays low.
- R10: The bits of the output control word that are not enable or mode bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from addr) |
| pwm_o | output | 6 | PWM outputs 1 to 6 (bit 0 is output 1) |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
A register write takes effect on the rising edge at which the strobe is sampled, and reads return combinationally. The bench therefore applies every write for one full cycle from a falling edge and samples read data 1 ns after setting the address.

Counter results follow from counting the rising edges that see the run bit high. With prescale 3, 42 such edges give exactly 10 ticks. Match actions take effect on the tick edge itself, so flags, the halt and the restart are visible on the next falling edge.

Each waveform check waits two full periods so that the first, partial period has passed. It then sums the high time over exactly one period of (MR0+1)·(prescale+1) falling edges. The result does not depend on the phase of the window.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // register addresses
   localparam int ADR_TCTL  = 0;
   localparam int ADR_PRESC = 1;
   localparam int ADR_MACT  = 2;
   localparam int ADR_OCTL  = 3;
   localparam int ADR_FLAG  = 4;
   localparam int ADR_TCNT  = 5;
   localparam int ADR_PCNT  = 6;
   localparam int ADR_MR0   = 8;
   // output control layout
   localparam int MODE_LSB  = 8;
   // action bit offsets inside each 3-bit match group
   localparam int ACT_IRQ   = 0;
   localparam int ACT_RST   = 1;
   localparam int ACT_HALT  = 2;
   localparam int ACT_BITS  = 3;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int TW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          hold_zero,
   input  logic [TW-1:0] limit,
   output logic [TW-1:0] pcnt,
   output logic          tick
);
   assign tick = run && !hold_zero && (pcnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pcnt <= '0;
      else if (hold_zero)  pcnt <= '0;
      else if (run)        pcnt <= tick ? '0 : pcnt + 1'b1;
   end
endmodule

// File: rtl/pwm_match_unit.sv
module pwm_match_unit import pwm_pkg::*; #(
   parameter int TW = 16,
   parameter int NM = 7
)(
   input  logic                 tick,
   input  logic [TW-1:0]        tcnt,
   input  logic [NM-1:0][TW-1:0] cmp,
   input  logic [ACT_BITS*NM-1:0] act,
   output logic [NM-1:0]        evt,
   output logic [NM-1:0]        irq_set,
   output logic                 do_restart,
   output logic                 do_halt
);
   logic [NM-1:0] rst_hit;
   logic [NM-1:0] halt_hit;

   for (genvar k = 0; k < NM; k++) begin : g_cmp
      assign evt[k]      = tick && (tcnt == cmp[k]);
      assign irq_set[k]  = evt[k] && act[ACT_BITS*k + ACT_IRQ];
      assign rst_hit[k]  = evt[k] && act[ACT_BITS*k + ACT_RST];
      assign halt_hit[k] = evt[k] && act[ACT_BITS*k + ACT_HALT];
   end

   assign do_restart = |rst_hit;
   assign do_halt    = |halt_hit;
endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_evt,
   input  logic enable,
   output logic pwm
);
   logic level_q;

   // a falling edge wins over a rising edge in the same tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       level_q <= 1'b0;
      else if (clr_evt) level_q <= 1'b0;
      else if (set_evt) level_q <= 1'b1;
   end

   assign pwm = enable & level_q;
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer import pwm_pkg::*; #(
   parameter int TW  = 16,
   parameter int NCH = 6,
   parameter int DW  = 32,
   parameter int AW  = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [NCH-1:0] pwm_o,
   output logic          irq_o
);
   localparam int NM  = NCH + 1;
   localparam int MCW = ACT_BITS * NM;

   if (NCH < 2 || NCH > 8) begin : g_bad_nch
      $error("pwm_match_timer: NCH must lie in 2..8");
   end
   if (TW < 2 || TW > DW) begin : g_bad_tw
      $error("pwm_match_timer: TW must lie in 2..DW");
   end
   if (MCW > DW || MODE_LSB + NCH - 1 > DW) begin : g_bad_dw
      $error("pwm_match_timer: DW too narrow for control words");
   end
   if (ADR_MR0 + NM > (1 << AW)) begin : g_bad_aw
      $error("pwm_match_timer: AW too narrow for compare registers");
   end

   logic                  run_q, hold_q;
   logic [TW-1:0]         presc_q;
   logic [MCW-1:0]        mact_q;
   logic [NCH-1:0]        oen_q;
   logic [NCH-1:0]        omode_q;
   logic [NM-1:0]         iflag_q;
   logic [NM-1:0][TW-1:0] cmp_q;
   logic [TW-1:0]         tcnt_q;
   logic [TW-1:0]         pcnt;
   logic                  tick;
   logic [NM-1:0]         evt, irq_set;
   logic                  do_restart, do_halt;
   logic                  unused_wbits;

   assign unused_wbits = ^wdata;

   function automatic logic hit(input logic [AW-1:0] a, input int target);
      return a == AW'(target);
   endfunction

   pwm_prescaler #(.TW(TW)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run_q), .hold_zero(hold_q),
      .limit(presc_q), .pcnt(pcnt), .tick(tick)
   );

   pwm_match_unit #(.TW(TW), .NM(NM)) u_match (
      .tick(tick), .tcnt(tcnt_q), .cmp(cmp_q), .act(mact_q),
      .evt(evt), .irq_set(irq_set),
      .do_restart(do_restart), .do_halt(do_halt)
   );

   // timer counter: halt freezes, restart zeroes, otherwise count ticks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tcnt_q <= '0;
      else if (hold_q)     tcnt_q <= '0;
      else if (do_halt)    tcnt_q <= tcnt_q;
      else if (do_restart) tcnt_q <= '0;
      else if (tick)       tcnt_q <= tcnt_q + 1'b1;
   end

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         hold_q  <= 1'b0;
         presc_q <= '0;
         mact_q  <= '0;
         oen_q   <= '0;
         omode_q <= '0;
      end else begin
         if (do_halt)
            run_q <= 1'b0;
         else if (wr_en && hit(addr, ADR_TCTL))
            run_q <= wdata[0];
         if (wr_en && hit(addr, ADR_TCTL))  hold_q  <= wdata[1];
         if (wr_en && hit(addr, ADR_PRESC)) presc_q <= wdata[TW-1:0];
         if (wr_en && hit(addr, ADR_MACT))  mact_q  <= wdata[MCW-1:0];
         if (wr_en && hit(addr, ADR_OCTL)) begin
            oen_q   <= wdata[NCH-1:0];
            omode_q <= {wdata[MODE_LSB +: NCH-1], 1'b0};
         end
      end
   end

   // compare registers
   for (genvar k = 0; k < NM; k++) begin : g_cmpreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_q[k] <= '0;
         else if (wr_en && hit(addr, ADR_MR0 + k))
            cmp_q[k] <= wdata[TW-1:0];
      end
   end

   // sticky flags: a new match wins over a clearing write
   logic [NM-1:0] flag_clr;
   assign flag_clr = (wr_en && hit(addr, ADR_FLAG)) ? wdata[NM-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) iflag_q <= '0;
      else        iflag_q <= (iflag_q & ~flag_clr) | irq_set;
   end

   assign irq_o = |iflag_q;

   // output channels; channel 0 has no mode select
   for (genvar i = 0; i < NCH; i++) begin : g_chan
      logic rise;
      if (i == 0) begin : g_single
         assign rise = evt[0];
      end else begin : g_dual
         assign rise = omode_q[i] ? evt[i] : evt[0];
      end
      pwm_edge_channel u_ch (
         .clk(clk), .rst_n(rst_n), .set_evt(rise), .clr_evt(evt[i+1]),
         .enable(oen_q[i]), .pwm(pwm_o[i])
      );
   end

   // read port
   always_comb begin
      rdata = '0;
      case (int'(addr))
         ADR_TCTL:  rdata[1:0] = {hold_q, run_q};
         ADR_PRESC: rdata[TW-1:0] = presc_q;
         ADR_MACT:  rdata[MCW-1:0] = mact_q;
         ADR_OCTL: begin
            rdata[NCH-1:0] = oen_q;
            rdata[MODE_LSB +: NCH-1] = omode_q[NCH-1:1];
         end
         ADR_FLAG:  rdata[NM-1:0] = iflag_q;
         ADR_TCNT:  rdata[TW-1:0] = tcnt_q;
         ADR_PCNT:  rdata[TW-1:0] = pcnt;
         default: begin
            for (int k = 0; k < NM; k++)
               if (hit(addr, ADR_MR0 + k)) rdata[TW-1:0] = cmp_q[k];
         end
      endcase
   end
endmodule

// File: rtl/pwm_match_timer_chk.sv
module pwm_match_timer_chk import pwm_pkg::*; #(
   parameter int TW = 16,
   parameter int NM = 7,
   parameter int AW = 4
)(
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          hold,
   input logic [TW-1:0] tcnt,
   input logic          do_halt,
   input logic          do_restart,
   input logic [NM-1:0] irq_set,
   input logic [NM-1:0] iflag,
   input logic          irq,
   input logic          wr_en,
   input logic [AW-1:0] addr
);
   logic flag_write;
   assign flag_write = wr_en && (addr == AW'(ADR_FLAG));

   // R2: a stopped counter keeps its value
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !hold) |=> $stable(tcnt));

   // R3: a restart action without a halt lands on zero
   assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (do_restart && !do_halt && !hold) |=> (tcnt == '0));

   // R4: a halt action freezes the counter and drops the run bit
   assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_halt && !hold) |=> (!run && $stable(tcnt)));

   // R5: an enabled match raises the interrupt on the next cycle
   assert_flag_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_set != '0) |=> irq);

   // R6: flags only drop through a flag write
   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((iflag != '0) && !flag_write) |=> irq);
endmodule

bind pwm_match_timer pwm_match_timer_chk #(.TW(TW), .NM(NCH+1), .AW(AW)) chk_i (
   .clk(clk), .rst_n(rst_n), .run(run_q), .hold(hold_q), .tcnt(tcnt_q),
   .do_halt(do_halt), .do_restart(do_restart), .irq_set(irq_set),
   .iflag(iflag_q), .irq(irq_o), .wr_en(wr_en), .addr(addr)
);

// File: tb/pwm_match_timer_tb_top.sv
module pwm_match_timer_tb_top;
   localparam int NV = 5;
   // pr, mr0, mr1, mr2, dbl
   localparam int VEC [NV][5] = '{
      '{0,  9, 3, 6, 0},
      '{0,  9, 3, 6, 1},
      '{2,  7, 1, 5, 1},
      '{3,  5, 0, 4, 0},
      '{1, 12, 4, 11, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [5:0]  pwm_o;
   logic        irq_o;
   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   pwm_match_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pwm_o(pwm_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      addr = 4'(a);
      #1 d = rdata;
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      // ---------- R1 reset state ----------
      apply_reset();
      for (int a = 0; a < 15; a++) begin
         rd(a, d);
         check("R1", $sformatf("reg %0d after reset", a), d, 0);
      end
      check("R1", "pwm after reset", pwm_o, 0);
      check("R1", "irq after reset", irq_o, 0);

      // ---------- vector table: R7 R8 R9 R3 ----------
      for (int v = 0; v < NV; v++) begin
         int pr, m0, m1, m2, dbl, per, h1, h2, hx, e1, e2;
         pr = VEC[v][0]; m0 = VEC[v][1]; m1 = VEC[v][2];
         m2 = VEC[v][3]; dbl = VEC[v][4];
         apply_reset();
         wr(1, pr); wr(8, m0); wr(9, m1); wr(10, m2);
         wr(2, 32'h2);                         // restart on compare 0
         wr(3, 32'h3 | (dbl << 8));            // outputs 1,2 enabled
         wr(0, 32'h1);
         per = (m0 + 1) * (pr + 1);
         repeat (2 * per + 4) @(negedge clk);
         h1 = 0; h2 = 0; hx = 0;
         for (int c = 0; c < per; c++) begin
            @(negedge clk);
            h1 += pwm_o[0];
            h2 += pwm_o[1];
            hx += (pwm_o[5:2] != 0);
         end
         e1 = (m1 + 1) * (pr + 1);
         e2 = dbl ? (m2 - m1) * (pr + 1) : (m2 + 1) * (pr + 1);
         check("R7", $sformatf("vec %0d out1 high clocks", v), h1, e1);
         check(dbl ? "R8" : "R7", $sformatf("vec %0d out2 high clocks", v), h2, e2);
         check("R9", $sformatf("vec %0d disabled outputs high", v), hx, 0);
         rd(5, d);
         check("R3", $sformatf("vec %0d counter within period", v), d <= m0, 1);
      end

      // ---------- R2 prescaler and hold ----------
      apply_reset();
      wr(1, 3); wr(8, 1000);
      wr(0, 1);
      repeat (40) @(negedge clk);
      wr(0, 0);                   // 42 running edges -> 10 ticks
      rd(5, d);
      check("R2", "ticks with prescale 3", d, 10);
      repeat (20) @(negedge clk);
      rd(5, d);
      check("R2", "counter holds when stopped", d, 10);
      wr(0, 2);                   // hold at zero
      rd(5, d);
      check("R2", "hold bit zeroes counter", d, 0);

      // ---------- R3 restart on a non-zero compare ----------
      apply_reset();
      wr(10, 3); wr(2, 32'h1 << 7);   // restart on compare 2
      wr(0, 1);
      begin
         int mx;
         mx = 0;
         for (int s = 0; s < 12; s++) begin
            rd(5, d);
            if (int'(d) > mx) mx = int'(d);
         end
         check("R3", "max counter with restart at 3", mx, 3);
      end

      // ---------- R4 halt ----------
      apply_reset();
      wr(11, 5); wr(2, 32'h1 << 11);  // halt on compare 3
      wr(0, 1);
      repeat (30) @(negedge clk);
      rd(5, d);
      check("R4", "counter frozen at match", d, 5);
      rd(0, d);
      check("R4", "run bit cleared", d, 0);

      // ---------- R5 R6 flags ----------
      apply_reset();
      wr(9, 2); wr(10, 4); wr(11, 6);
      wr(2, (32'h1 << 6) | (32'h1 << 11));  // irq on 2, halt on 3
      wr(0, 1);
      repeat (20) @(negedge clk);
      rd(4, d);
      check("R5", "only enabled flag set", d, 32'h4);
      check("R5", "irq is OR of flags", irq_o, 1);
      wr(4, 32'h2);
      rd(4, d);
      check("R6", "clear of unset bit keeps flag", d, 32'h4);
      check("R6", "irq kept", irq_o, 1);
      wr(4, 32'h4);
      rd(4, d);
      check("R6", "write 1 clears flag", d, 0);
      check("R6", "irq dropped", irq_o, 0);

      // ---------- R10 reserved output control bits ----------
      wr(3, 32'hFFFF_FFFF);
      rd(3, d);
      check("R10", "output control readback", d, 32'h1F3F);

      // ---------- R9 disable an active output ----------
      apply_reset();
      wr(8, 9); wr(9, 8); wr(2, 32'h2); wr(3, 32'h1); wr(0, 1);
      repeat (15) @(negedge clk);
      wr(3, 32'h0);
      begin
         int hi;
         hi = 0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            hi += pwm_o[0];
         end
         check("R9", "disabled out1 high clocks", hi, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule